// File: doc/BRIEF.md
# Electrically Erasable Byte ROM Model

This block is a clocked, synthesizable stand-in for a byte-wide, electrically erasable read-only memory. It is meant for system simulation and emulation, where a board's boot store must behave like the real part. The analog conditions the real part needs are reduced to digital flags: one for the programming supply, one for the erase supply, and one for the high-voltage level on address line 9. Each cycle the block decodes an operating mode from these flags and the two active-low controls. It then drives a stored byte or an identifier byte, or it holds its outputs off.

The data bus is split into an input byte, an output byte and an output-enable. The output-enable stands for the tristate buffer. Reads are combinational from the address. Writes take effect on the rising clock edge in which the mode is valid. A write can only clear bits, and only a whole-array erase can set them again. The erase finishes in one cycle. The full-size organisation is 2^19 bytes, but the address width is a parameter and defaults to a small value for simulation.

Top module: `erom_model`

## Requirements
- R1: With neither supply flag set, chip-enable low, output-enable low and the A9 high-voltage flag clear, `data_oe_o` is 1 and `data_o` equals the stored byte at `addr_i`.
- R2: With neither supply flag set, chip-enable low and output-enable high, `data_oe_o` is 0.
- R3: With neither supply flag set and chip-enable high, `data_oe_o` is 0 whatever output-enable is.
- R4: With only the program flag set, chip-enable low and output-enable high, the byte at `addr_i` becomes (old byte AND `data_i`) at the rising clock edge, and `data_oe_o` is 0.
- R5: With only the erase flag set, chip-enable low, output-enable high, the A9 high-voltage flag set and `addr_i` all zero, every byte becomes FF hex at the rising edge. If any address bit is 1 under the same controls, no byte changes.
- R6: With exactly one supply flag set, chip-enable high and output-enable low (verify), `data_oe_o` is 1 and `data_o` is the stored byte at `addr_i`.
- R7: With exactly one supply flag set and either both controls high or both controls low, no byte changes and `data_oe_o` is 0.
- R8: With neither supply flag set, the A9 high-voltage flag set and both controls low, `data_oe_o` is 1. `data_o` is DA hex when `addr_i[0]` is 0 and 86 hex when it is 1.
- R9: After reset every byte of the array reads FF hex.
- R10: With both supply flags set, `err_o` is 1, `data_oe_o` is 0 and no byte changes. Otherwise `err_o` is 0.

Ports, in the order of the top module's port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; program and erase act on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; fills the array with FF |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Byte to program |
| data_o | output | 8 | Byte driven onto the bus (0 when not driving) |
| data_oe_o | output | 1 | Bus drive enable; 0 means high impedance |
| ce_ni | input | 1 | Chip-enable, active low |
| oe_ni | input | 1 | Output-enable, active low |
| vpp_prog_i | input | 1 | Programming supply present |
| vpp_erase_i | input | 1 | Erase supply present |
| a9_hv_i | input | 1 | High-voltage level on address line 9 |
| err_o | output | 1 | Both supply flags set at once |

## Verification
The assertions take it that the inputs are steady around each rising edge. They also take it that the address a verify looks at is the one the preceding program cycle wrote. The program and erase checks are only armed in a verify cycle that directly follows the write. The bench changes inputs only on falling edges. It mixes random mode selections with a biased share of the exact erase condition (address zero with the A9 flag set), so that whole-array erases recur between stretches of bit-clearing writes.

// File: rtl/erom_pkg.sv
package erom_pkg;

  typedef enum logic [3:0] {
    MODE_STANDBY,
    MODE_OUT_OFF,
    MODE_READ,
    MODE_IDENT,
    MODE_PROG,
    MODE_ERASE,
    MODE_VERIFY,
    MODE_INHIBIT,
    MODE_ILLEGAL
  } erom_mode_e;

  localparam logic [7:0] ID_MAKER    = 8'hDA;
  localparam logic [7:0] ID_PART     = 8'h86;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/erom_mode_dec.sv
module erom_mode_dec
  import erom_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_prog_i,
  input  logic              vpp_erase_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output erom_mode_e        mode_o
);

  logic write_sel, verify_sel, addr_zero;

  assign write_sel  = !ce_ni &&  oe_ni;
  assign verify_sel =  ce_ni && !oe_ni;
  assign addr_zero  = (addr_i == '0);

  always_comb begin
    mode_o = MODE_INHIBIT;
    case ({vpp_prog_i, vpp_erase_i})
      2'b00: begin
        if (ce_ni)        mode_o = MODE_STANDBY;
        else if (oe_ni)   mode_o = MODE_OUT_OFF;
        else if (a9_hv_i) mode_o = MODE_IDENT;
        else              mode_o = MODE_READ;
      end
      2'b10: begin
        if (write_sel)       mode_o = MODE_PROG;
        else if (verify_sel) mode_o = MODE_VERIFY;
        else                 mode_o = MODE_INHIBIT;
      end
      2'b01: begin
        if (write_sel)       mode_o = (a9_hv_i && addr_zero) ? MODE_ERASE : MODE_INHIBIT;
        else if (verify_sel) mode_o = MODE_VERIFY;
        else                 mode_o = MODE_INHIBIT;
      end
      default: mode_o = MODE_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/erom_array.sv
module erom_array
  import erom_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] rd_bus [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic       hit;
    logic [7:0] byte_q;

    assign hit = prog_i && (addr_i == ADDR_W'(g));

    // bits may only fall on program, only a full erase raises them
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      byte_q <= ERASED_BYTE;
      else if (erase_i) byte_q <= ERASED_BYTE;
      else if (hit)     byte_q <= byte_q & wdata_i;
    end

    assign rd_bus[g] = byte_q;
  end

  assign rdata_o = rd_bus[addr_i];

endmodule

// File: rtl/erom_outsel.sv
module erom_outsel
  import erom_pkg::*;
(
  input  erom_mode_e mode_i,
  input  logic [7:0] rdata_i,
  input  logic       addr_lsb_i,
  output logic [7:0] data_o,
  output logic       data_oe_o
);

  always_comb begin
    data_o    = 8'h00;
    data_oe_o = 1'b0;
    case (mode_i)
      MODE_READ, MODE_VERIFY: begin
        data_o    = rdata_i;
        data_oe_o = 1'b1;
      end
      MODE_IDENT: begin
        data_o    = addr_lsb_i ? ID_PART : ID_MAKER;
        data_oe_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/erom_model.sv
module erom_model
  import erom_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_prog_i,
  input  logic              vpp_erase_i,
  input  logic              a9_hv_i,
  output logic              err_o
);

  erom_mode_e mode;
  logic [7:0] rdata;

  erom_mode_dec #(.ADDR_W(ADDR_W)) i_dec (
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .vpp_prog_i (vpp_prog_i),
    .vpp_erase_i(vpp_erase_i),
    .a9_hv_i    (a9_hv_i),
    .addr_i     (addr_i),
    .mode_o     (mode)
  );

  erom_array #(.ADDR_W(ADDR_W)) i_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prog_i (mode == MODE_PROG),
    .erase_i(mode == MODE_ERASE),
    .addr_i (addr_i),
    .wdata_i(data_i),
    .rdata_o(rdata)
  );

  erom_outsel i_out (
    .mode_i    (mode),
    .rdata_i   (rdata),
    .addr_lsb_i(addr_i[0]),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  assign err_o = (mode == MODE_ILLEGAL);

endmodule

// File: rtl/erom_model_chk.sv
module erom_model_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_i,
  input logic [7:0]        data_o,
  input logic              data_oe_o,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              vpp_prog_i,
  input logic              vpp_erase_i,
  input logic              a9_hv_i,
  input logic              err_o
);

  logic no_hv, only_prog, only_erase;
  assign no_hv      = !vpp_prog_i && !vpp_erase_i;
  assign only_prog  =  vpp_prog_i && !vpp_erase_i;
  assign only_erase = !vpp_prog_i &&  vpp_erase_i;

  // R1
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_hv && !ce_ni && !oe_ni && !a9_hv_i) |-> data_oe_o);

  // R2
  out_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_hv && !ce_ni && oe_ni) |-> !data_oe_o);

  // R3
  standby_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_hv && ce_ni) |-> !data_oe_o);

  // R4
  prog_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_prog && !ce_ni && oe_ni) |=>
      ((only_prog && ce_ni && !oe_ni && addr_i == $past(addr_i)) ->
        ((data_o & ~$past(data_i)) == 8'h00)));

  // R4
  prog_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_prog && !ce_ni && oe_ni) |-> !data_oe_o);

  // R5
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_erase && !ce_ni && oe_ni && a9_hv_i && addr_i == '0) |=>
      ((only_erase && ce_ni && !oe_ni) -> (data_o == 8'hFF)));

  // R6
  verify_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((only_prog || only_erase) && ce_ni && !oe_ni) |-> data_oe_o);

  // R7
  inhibit_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((only_prog || only_erase) && (ce_ni == oe_ni)) |-> !data_oe_o);

  // R8
  ident_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_hv && !ce_ni && !oe_ni && a9_hv_i) |->
      (data_oe_o && data_o == (addr_i[0] ? 8'h86 : 8'hDA)));

  // R10
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_prog_i && vpp_erase_i) |-> (err_o && !data_oe_o));

  // R10
  legal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vpp_prog_i && vpp_erase_i) |-> !err_o);

endmodule

bind erom_model erom_model_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .data_i     (data_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .ce_ni      (ce_ni),
  .oe_ni      (oe_ni),
  .vpp_prog_i (vpp_prog_i),
  .vpp_erase_i(vpp_erase_i),
  .a9_hv_i    (a9_hv_i),
  .err_o      (err_o)
);

// File: tb/test_erom_model.sv
module test_erom_model;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 6;
  localparam int DEPTH      = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;
  logic          ce_n = 1'b1, oe_n = 1'b1, vp = 1'b0, ve = 1'b0, a9 = 1'b0;
  logic          err;

  int chk_cnt = 0;
  int fail_cnt = 0;
  logic [7:0] exp_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  erom_model #(.ADDR_W(AW)) i_erom_model (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .data_i(din),
    .data_o(dout), .data_oe_o(dout_en), .ce_ni(ce_n), .oe_ni(oe_n),
    .vpp_prog_i(vp), .vpp_erase_i(ve), .a9_hv_i(a9), .err_o(err)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    chk_cnt++;
    if (act !== exp) begin
      fail_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_tag();
    if (vp && ve) return "R10";
    if (!vp && !ve) begin
      if (ce_n) return "R3";
      if (oe_n) return "R2";
      if (a9) return "R8";
      return "R1";
    end
    if (ce_n && !oe_n) return "R6";
    if (!ce_n && oe_n) return vp ? "R4" : "R5";
    return "R7";
  endfunction

  // expected {drive, byte}
  function automatic logic [8:0] exp_bus();
    if (vp && ve) return 9'h000;
    if (!vp && !ve) begin
      if (ce_n || oe_n) return 9'h000;
      if (a9) return {1'b1, addr[0] ? 8'h86 : 8'hDA};
      return {1'b1, exp_mem[addr]};
    end
    if (ce_n && !oe_n) return {1'b1, exp_mem[addr]};
    return 9'h000;
  endfunction

  task automatic apply(input logic c, input logic o, input logic p, input logic e,
                       input logic h, input logic [AW-1:0] a, input logic [7:0] d);
    string tag;
    bit    do_prog, do_erase;
    ce_n = c; oe_n = o; vp = p; ve = e; a9 = h; addr = a; din = d;
    #1;
    tag = req_tag();
    chk(tag, {dout_en, dout}, exp_bus());
    chk("R10", {8'h00, err}, {8'h00, p && e});
    do_prog  = p && !e && !c && o;
    do_erase = e && !p && !c && o && h && (a == '0);
    @(posedge clk);
    if (do_erase) for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    else if (do_prog) exp_mem[a] = exp_mem[a] & d;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fail_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd0,  8'h00);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd37, 8'h00);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd63, 8'h00);
    chk("R9", {1'b0, dout}, 9'h0FF);
    // R4 program then AND, R6 verify, R1 read
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd3, 8'hF0);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'd3, 8'h00);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd3, 8'h3C);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, 8'h00);
    chk("R4", {1'b0, dout}, 9'h030);
    // R10 illegal does not write
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0, 8'h00);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd5, 8'h00);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00);
    chk("R10", {1'b0, dout}, 9'h0FF);
    // R7 inhibit, both controls high or low
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd5, 8'h00);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd5, 8'h00);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00);
    chk("R7", {1'b0, dout}, 9'h0FF);
    // R3 standby with output-enable low
    apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd3, 8'h00);
    // R8 identifiers
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 8'h00);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 8'h00);
    // R5 erase with nonzero address is ignored, then real erase
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd32, 8'h00);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd3, 8'h00);
    chk("R5", {1'b0, dout}, 9'h030);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd0, 8'h00);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd3, 8'h00);
    chk("R5", {1'b0, dout}, 9'h0FF);

    for (int n = 0; n < 3000; n++) begin
      int unsigned sel;
      logic [AW-1:0] ra;
      logic [7:0]    rd;
      sel = $urandom % 10;
      ra  = AW'($urandom);
      rd  = 8'($urandom) | 8'($urandom);
      case (sel)
        0, 1, 2: apply(1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'($urandom), ra, rd);
        3, 4:    apply(1'($urandom), 1'($urandom), 1'b1, 1'b0, 1'($urandom), ra, rd);
        5:       apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, ($urandom % 3 == 0) ? '0 : ra, rd);
        6:       apply(1'($urandom), 1'($urandom), 1'b0, 1'b1, 1'($urandom), ra, rd);
        7:       apply(1'b1, 1'b0, 1'($urandom), 1'b0, 1'($urandom), ra, rd);
        8:       apply(1'($urandom), 1'($urandom), 1'b1, 1'b1, 1'($urandom), ra, rd);
        default: apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, ra, rd);
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chk_cnt, fail_cnt);
    $finish;
  end

endmodule